// File: doc/BRIEF.md
# Stack-Aware Control Decoder for a Single-Cycle Core

This block sits between the instruction fetch logic and the datapath of a single-cycle processor. Each cycle it takes the primary opcode, the function nibble and the two register fields of the instruction being executed, together with the current condition flags. From these it produces every steering signal the datapath needs. These are the two register read addresses, the two register write addresses and their enables, the ALU operand and function selects, the flag-update strobe, the memory read and write strobes, the memory address and write-data selects, and the next-PC select. The block is purely combinational.

Push, pop, call and return name the stack pointer implicitly. Push and call form the new stack pointer by subtracting four and use that value as the memory address. Pop and return add four for the new stack pointer but read memory at the old one. The register file has two write ports: E carries the ALU result and M carries the value loaded from memory. When both ports name the same register, the M port wins. As a result, popping the stack pointer leaves it holding the word read from the old top of stack.

Register identifiers are 4 bits wide. Identifier 4 is the stack pointer and identifier 8 means "no register". Opcodes are: 0 idle, 1 halt, 2 ALU operation, 3 register-to-register move, 4 immediate-to-register move, 5 register-to-memory store, 6 memory-to-register load, 7 jump, 8 call, 9 return, A push, B pop; C through F are undefined.

Top module: `cd_top`

## Requirements
- R1: An opcode of C–F, an ALU operation with function above 3, or a jump with function above 6 raises `illegal`. In that case `wr_e_en`, `wr_m_en`, `mem_rd`, `mem_wr`, `cc_update`, `branch_taken` and `halt` are all 0 and `pc_sel` is 0. Opcode 1 raises `halt` and nothing else. For every other opcode, the function nibble has no effect.
- R2: `src_a` is `reg_a` for ALU operation, register move, store and push. It is 4 for pop and return, and 8 otherwise.
- R3: `src_b` is `reg_b` for ALU operation, store and load. It is 4 for push, pop, call and return, and 8 otherwise.
- R4: `dst_e` is `reg_b` for register move, immediate move and ALU operation. It is 4 for push, pop, call and return, and 8 otherwise.
- R5: `dst_m` is `reg_a` for load and pop, and 8 otherwise.
- R6: `wr_m_en` is 1 exactly when `dst_m` is not 8. `wr_e_en` is 1 when `dst_e` is not 8, unless `dst_e` equals `dst_m`; in that case only `wr_m_en` is set.
- R7: `alu_a_sel` selects the first ALU operand: 0 = register A value, 1 = constant, 2 = minus four, 3 = plus four. It is 0 for ALU operation and register move, 1 for immediate move, store and load, 2 for push and call, 3 for pop and return, and 0 otherwise. `alu_b_sel` is 1 (register B value) for ALU operation, store, load, push, pop, call and return, and 0 (zero) otherwise.
- R8: `cc_update` is 1 only for a legal ALU operation. In that case `alu_fn` equals the low two bits of `op_fn` (0 add, 1 subtract, 2 and, 3 xor); otherwise `alu_fn` is 0.
- R9: `mem_wr` is 1 for store, push and call. `mem_rd` is 1 for load, pop and return. Both are 0 otherwise.
- R10: `mem_addr_sel` is 1 (old stack pointer, the register A value) for pop and return, and 0 (ALU result) otherwise. `mem_data_sel` is 1 (return address) for call, and 0 (register A value) otherwise.
- R11: `flags` bit 0 is zero, bit 1 is sign and bit 2 is overflow; let less = sign xor overflow. A legal jump is taken for these functions: 0 always; 1 when less or zero; 2 when less; 3 when zero; 4 when not zero; 5 when not less; 6 when neither less nor zero. `branch_taken` is 1 only for a taken jump.
- R12: `pc_sel` is 1 (constant) for call and for a taken jump, 2 (loaded word) for return, and 0 (sequential) otherwise.
- R13: A push of register 4 reads register 4 through `src_a` and stores the register A value (`mem_data_sel` 0). The stored word is therefore the stack pointer before the decrement.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_code | input | 4 | Primary opcode |
| op_fn | input | 4 | Function nibble |
| reg_a | input | 4 | First register field |
| reg_b | input | 4 | Second register field |
| flags | input | 3 | Condition flags {overflow, sign, zero} |
| src_a | output | 4 | Register read address A |
| src_b | output | 4 | Register read address B |
| dst_e | output | 4 | Write address, ALU-result port |
| dst_m | output | 4 | Write address, memory-data port |
| wr_e_en | output | 1 | Write enable, E port after arbitration |
| wr_m_en | output | 1 | Write enable, M port |
| alu_a_sel | output | 2 | First ALU operand select |
| alu_b_sel | output | 1 | Second ALU operand select |
| alu_fn | output | 2 | ALU function |
| cc_update | output | 1 | Condition flag update strobe |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr_sel | output | 1 | Memory address select |
| mem_data_sel | output | 1 | Memory write data select |
| pc_sel | output | 2 | Next-PC select |
| branch_taken | output | 1 | Jump condition satisfied |
| halt | output | 1 | Halt instruction |
| illegal | output | 1 | Undefined encoding |

## Verification
The hardest case is the write-port collision. It arises only when a pop names the stack pointer as its destination, so the register field and the opcode must line up exactly. The stimulus sweeps every opcode and function nibble against register fields that include 4 and 8, under all eight flag patterns. This lands on the collision, on the push of the stack pointer and on every jump condition. Directed checks then repeat the pop and push cases with fixed expected values.

// File: rtl/cd_pkg.sv
package cd_pkg;

  localparam logic [3:0] OP_IDLE  = 4'h0;
  localparam logic [3:0] OP_HALT  = 4'h1;
  localparam logic [3:0] OP_ALU   = 4'h2;
  localparam logic [3:0] OP_RRMOV = 4'h3;
  localparam logic [3:0] OP_IRMOV = 4'h4;
  localparam logic [3:0] OP_STORE = 4'h5;
  localparam logic [3:0] OP_LOAD  = 4'h6;
  localparam logic [3:0] OP_JUMP  = 4'h7;
  localparam logic [3:0] OP_CALL  = 4'h8;
  localparam logic [3:0] OP_RET   = 4'h9;
  localparam logic [3:0] OP_PUSH  = 4'hA;
  localparam logic [3:0] OP_POP   = 4'hB;

  typedef enum logic [3:0] {
    K_IDLE, K_HALT, K_ALU, K_RRMOV, K_IRMOV, K_STORE, K_LOAD,
    K_JUMP, K_CALL, K_RET, K_PUSH, K_POP, K_BAD
  } kind_e;

  typedef enum logic [1:0] {
    A_VALA = 2'd0, A_VALC = 2'd1, A_DEC = 2'd2, A_INC = 2'd3
  } alu_a_e;

  typedef enum logic [1:0] {
    PC_SEQ = 2'd0, PC_CONST = 2'd1, PC_MEM = 2'd2
  } pc_e;

  // Jump condition on {overflow, sign, zero}.
  function automatic logic cond_holds(input logic [3:0] fn, input logic [2:0] fl);
    logic zf, less;
    zf   = fl[0];
    less = fl[1] ^ fl[2];
    case (fn)
      4'd0:    cond_holds = 1'b1;
      4'd1:    cond_holds = less | zf;
      4'd2:    cond_holds = less;
      4'd3:    cond_holds = zf;
      4'd4:    cond_holds = ~zf;
      4'd5:    cond_holds = ~less;
      4'd6:    cond_holds = ~less & ~zf;
      default: cond_holds = 1'b0;
    endcase
  endfunction

  // Instructions that address the stack pointer implicitly.
  function automatic logic uses_stack(input kind_e k);
    uses_stack = (k == K_PUSH) || (k == K_POP) || (k == K_CALL) || (k == K_RET);
  endfunction

endpackage

// File: rtl/cd_classify.sv
module cd_classify
  import cd_pkg::*;
#(
  parameter int ALU_FN_COUNT = 4,
  parameter int JMP_FN_COUNT = 7
) (
  input  logic [3:0] op_code,
  input  logic [3:0] op_fn,
  output kind_e      kind,
  output logic       halt,
  output logic       illegal
);

  localparam logic [4:0] ALU_LIM = 5'(ALU_FN_COUNT);
  localparam logic [4:0] JMP_LIM = 5'(JMP_FN_COUNT);

  logic alu_fn_ok;
  logic jmp_fn_ok;

  assign alu_fn_ok = {1'b0, op_fn} < ALU_LIM;
  assign jmp_fn_ok = {1'b0, op_fn} < JMP_LIM;

  always_comb begin
    case (op_code)
      OP_IDLE:  kind = K_IDLE;
      OP_HALT:  kind = K_HALT;
      OP_ALU:   kind = alu_fn_ok ? K_ALU : K_BAD;
      OP_RRMOV: kind = K_RRMOV;
      OP_IRMOV: kind = K_IRMOV;
      OP_STORE: kind = K_STORE;
      OP_LOAD:  kind = K_LOAD;
      OP_JUMP:  kind = jmp_fn_ok ? K_JUMP : K_BAD;
      OP_CALL:  kind = K_CALL;
      OP_RET:   kind = K_RET;
      OP_PUSH:  kind = K_PUSH;
      OP_POP:   kind = K_POP;
      default:  kind = K_BAD;
    endcase
  end

  assign halt    = (kind == K_HALT);
  assign illegal = (kind == K_BAD);

endmodule

// File: rtl/cd_regsel.sv
module cd_regsel
  import cd_pkg::*;
#(
  parameter int REG_W   = 4,
  parameter int SP_ID   = 4,
  parameter int NONE_ID = 8
) (
  input  kind_e            kind,
  input  logic [REG_W-1:0] reg_a,
  input  logic [REG_W-1:0] reg_b,
  output logic [REG_W-1:0] src_a,
  output logic [REG_W-1:0] src_b,
  output logic [REG_W-1:0] dst_e,
  output logic [REG_W-1:0] dst_m
);

  localparam logic [REG_W-1:0] SP   = REG_W'(SP_ID);
  localparam logic [REG_W-1:0] NONE = REG_W'(NONE_ID);

  logic stack_op;
  assign stack_op = uses_stack(kind);

  always_comb begin
    case (kind)
      K_ALU, K_RRMOV, K_STORE, K_PUSH: src_a = reg_a;
      K_POP, K_RET:                    src_a = SP;
      default:                         src_a = NONE;
    endcase
  end

  always_comb begin
    if (stack_op)
      src_b = SP;
    else if (kind == K_ALU || kind == K_STORE || kind == K_LOAD)
      src_b = reg_b;
    else
      src_b = NONE;
  end

  always_comb begin
    if (stack_op)
      dst_e = SP;
    else if (kind == K_ALU || kind == K_RRMOV || kind == K_IRMOV)
      dst_e = reg_b;
    else
      dst_e = NONE;
  end

  assign dst_m = (kind == K_LOAD || kind == K_POP) ? reg_a : NONE;

endmodule

// File: rtl/cd_wport.sv
module cd_wport #(
  parameter int REG_W   = 4,
  parameter int NONE_ID = 8,
  parameter bit M_WINS  = 1'b1
) (
  input  logic [REG_W-1:0] dst_e,
  input  logic [REG_W-1:0] dst_m,
  output logic             wr_e_en,
  output logic             wr_m_en,
  output logic             clash
);

  localparam logic [REG_W-1:0] NONE = REG_W'(NONE_ID);

  logic e_named;
  logic m_named;

  assign e_named = (dst_e != NONE);
  assign m_named = (dst_m != NONE);
  assign clash   = e_named && m_named && (dst_e == dst_m);

  generate
    if (M_WINS) begin : g_m_priority
      assign wr_m_en = m_named;
      assign wr_e_en = e_named && !clash;
    end else begin : g_e_priority
      assign wr_e_en = e_named;
      assign wr_m_en = m_named && !clash;
    end
  endgenerate

endmodule

// File: rtl/cd_exmem.sv
module cd_exmem
  import cd_pkg::*;
(
  input  kind_e      kind,
  input  logic [1:0] fn_lo,
  output alu_a_e     alu_a_sel,
  output logic       alu_b_sel,
  output logic [1:0] alu_fn,
  output logic       cc_update,
  output logic       mem_rd,
  output logic       mem_wr,
  output logic       mem_addr_sel,
  output logic       mem_data_sel
);

  always_comb begin
    case (kind)
      K_IRMOV, K_STORE, K_LOAD: alu_a_sel = A_VALC;
      K_PUSH, K_CALL:           alu_a_sel = A_DEC;
      K_POP, K_RET:             alu_a_sel = A_INC;
      default:                  alu_a_sel = A_VALA;
    endcase
  end

  always_comb begin
    case (kind)
      K_ALU, K_STORE, K_LOAD, K_PUSH, K_POP, K_CALL, K_RET: alu_b_sel = 1'b1;
      default:                                              alu_b_sel = 1'b0;
    endcase
  end

  assign cc_update = (kind == K_ALU);
  assign alu_fn    = cc_update ? fn_lo : 2'd0;

  assign mem_wr       = (kind == K_STORE) || (kind == K_PUSH) || (kind == K_CALL);
  assign mem_rd       = (kind == K_LOAD) || (kind == K_POP) || (kind == K_RET);
  assign mem_addr_sel = (kind == K_POP) || (kind == K_RET);
  assign mem_data_sel = (kind == K_CALL);

endmodule

// File: rtl/cd_pcsel.sv
module cd_pcsel
  import cd_pkg::*;
(
  input  kind_e      kind,
  input  logic [3:0] op_fn,
  input  logic [2:0] flags,
  output logic       branch_taken,
  output pc_e        pc_sel
);

  assign branch_taken = (kind == K_JUMP) && cond_holds(op_fn, flags);

  always_comb begin
    if (kind == K_RET)
      pc_sel = PC_MEM;
    else if (kind == K_CALL || branch_taken)
      pc_sel = PC_CONST;
    else
      pc_sel = PC_SEQ;
  end

endmodule

// File: rtl/cd_top.sv
module cd_top
  import cd_pkg::*;
#(
  parameter int REG_W        = 4,
  parameter int SP_ID        = 4,
  parameter int NONE_ID      = 8,
  parameter int ALU_FN_COUNT = 4,
  parameter int JMP_FN_COUNT = 7
) (
  input  logic [3:0]       op_code,
  input  logic [3:0]       op_fn,
  input  logic [REG_W-1:0] reg_a,
  input  logic [REG_W-1:0] reg_b,
  input  logic [2:0]       flags,
  output logic [REG_W-1:0] src_a,
  output logic [REG_W-1:0] src_b,
  output logic [REG_W-1:0] dst_e,
  output logic [REG_W-1:0] dst_m,
  output logic             wr_e_en,
  output logic             wr_m_en,
  output logic [1:0]       alu_a_sel,
  output logic             alu_b_sel,
  output logic [1:0]       alu_fn,
  output logic             cc_update,
  output logic             mem_rd,
  output logic             mem_wr,
  output logic             mem_addr_sel,
  output logic             mem_data_sel,
  output logic [1:0]       pc_sel,
  output logic             branch_taken,
  output logic             halt,
  output logic             illegal
);

  kind_e  kind;
  alu_a_e alu_a_k;
  pc_e    pc_k;
  logic   wr_clash;

  cd_classify #(
    .ALU_FN_COUNT (ALU_FN_COUNT),
    .JMP_FN_COUNT (JMP_FN_COUNT)
  ) u_classify (
    .op_code (op_code),
    .op_fn   (op_fn),
    .kind    (kind),
    .halt    (halt),
    .illegal (illegal)
  );

  cd_regsel #(
    .REG_W   (REG_W),
    .SP_ID   (SP_ID),
    .NONE_ID (NONE_ID)
  ) u_regsel (
    .kind  (kind),
    .reg_a (reg_a),
    .reg_b (reg_b),
    .src_a (src_a),
    .src_b (src_b),
    .dst_e (dst_e),
    .dst_m (dst_m)
  );

  cd_wport #(
    .REG_W   (REG_W),
    .NONE_ID (NONE_ID),
    .M_WINS  (1'b1)
  ) u_wport (
    .dst_e   (dst_e),
    .dst_m   (dst_m),
    .wr_e_en (wr_e_en),
    .wr_m_en (wr_m_en),
    .clash   (wr_clash)
  );

  cd_exmem u_exmem (
    .kind         (kind),
    .fn_lo        (op_fn[1:0]),
    .alu_a_sel    (alu_a_k),
    .alu_b_sel    (alu_b_sel),
    .alu_fn       (alu_fn),
    .cc_update    (cc_update),
    .mem_rd       (mem_rd),
    .mem_wr       (mem_wr),
    .mem_addr_sel (mem_addr_sel),
    .mem_data_sel (mem_data_sel)
  );

  cd_pcsel u_pcsel (
    .kind         (kind),
    .op_fn        (op_fn),
    .flags        (flags),
    .branch_taken (branch_taken),
    .pc_sel       (pc_k)
  );

  assign alu_a_sel = alu_a_k;
  assign pc_sel    = pc_k;

endmodule

// File: rtl/cd_top_chk.sv
module cd_top_chk #(
  parameter int REG_W   = 4,
  parameter int SP_ID   = 4,
  parameter int NONE_ID = 8
) (
  input logic [3:0]       op_code,
  input logic [REG_W-1:0] reg_a,
  input logic [REG_W-1:0] src_a,
  input logic [REG_W-1:0] src_b,
  input logic [REG_W-1:0] dst_m,
  input logic             wr_e_en,
  input logic             wr_m_en,
  input logic             wr_clash,
  input logic [1:0]       alu_a_sel,
  input logic             alu_b_sel,
  input logic             cc_update,
  input logic             mem_rd,
  input logic             mem_wr,
  input logic             mem_addr_sel,
  input logic             mem_data_sel,
  input logic [1:0]       pc_sel,
  input logic             branch_taken,
  input logic             halt,
  input logic             illegal
);

  localparam logic [REG_W-1:0] SP   = REG_W'(SP_ID);
  localparam logic [REG_W-1:0] NONE = REG_W'(NONE_ID);

  always_comb begin
    if (!$isunknown(op_code)) begin
      assert_illegal_quiet_R1: assert (!illegal ||
        (!wr_e_en && !wr_m_en && !mem_rd && !mem_wr && !cc_update &&
         !branch_taken && !halt && pc_sel == 2'd0))
        else $error("illegal encoding produced side effects");
      assert_push_src_R2: assert (op_code != 4'hA || src_a == reg_a)
        else $error("push does not read its register field");
      assert_stack_base_R3: assert (alu_a_sel < 2'd2 || src_b == SP)
        else $error("stack adjust without stack pointer operand");
      assert_load_reads_R5: assert (dst_m == NONE || mem_rd)
        else $error("M port named without a memory read");
      assert_m_wins_R6: assert (!wr_clash || (wr_m_en && !wr_e_en))
        else $error("E port not suppressed on collision");
      assert_stack_b_R7: assert (alu_a_sel < 2'd2 || alu_b_sel)
        else $error("stack adjust without register B operand");
      assert_cc_alu_only_R8: assert (!cc_update || (alu_a_sel == 2'd0 && alu_b_sel && !mem_rd && !mem_wr))
        else $error("flag update outside an ALU operation");
      assert_mem_excl_R9: assert (!(mem_rd && mem_wr))
        else $error("memory read and write together");
      assert_retaddr_R10: assert (!mem_data_sel || (mem_wr && pc_sel == 2'd1))
        else $error("return address stored outside a call");
      assert_taken_const_R11: assert (!branch_taken || pc_sel == 2'd1)
        else $error("taken jump not steering to constant");
      assert_ret_mem_R12: assert (pc_sel != 2'd2 || (mem_rd && mem_addr_sel))
        else $error("loaded next PC without read at old stack pointer");
      assert_push_old_R13: assert (op_code != 4'hA || !mem_data_sel)
        else $error("push not storing register A value");
    end
  end

endmodule

bind cd_top cd_top_chk #(
  .REG_W   (REG_W),
  .SP_ID   (SP_ID),
  .NONE_ID (NONE_ID)
) u_chk (
  .op_code      (op_code),
  .reg_a        (reg_a),
  .src_a        (src_a),
  .src_b        (src_b),
  .dst_m        (dst_m),
  .wr_e_en      (wr_e_en),
  .wr_m_en      (wr_m_en),
  .wr_clash     (wr_clash),
  .alu_a_sel    (alu_a_sel),
  .alu_b_sel    (alu_b_sel),
  .cc_update    (cc_update),
  .mem_rd       (mem_rd),
  .mem_wr       (mem_wr),
  .mem_addr_sel (mem_addr_sel),
  .mem_data_sel (mem_data_sel),
  .pc_sel       (pc_sel),
  .branch_taken (branch_taken),
  .halt         (halt),
  .illegal      (illegal)
);

// File: tb/cd_top_tb.sv
module cd_top_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [3:0] op_code, op_fn, reg_a, reg_b;
  logic [2:0] flags;
  logic [3:0] src_a, src_b, dst_e, dst_m;
  logic       wr_e_en, wr_m_en, alu_b_sel, cc_update, mem_rd, mem_wr;
  logic       mem_addr_sel, mem_data_sel, branch_taken, halt, illegal;
  logic [1:0] alu_a_sel, alu_fn, pc_sel;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;

  cd_top u_dut (
    .op_code (op_code), .op_fn (op_fn), .reg_a (reg_a), .reg_b (reg_b), .flags (flags),
    .src_a (src_a), .src_b (src_b), .dst_e (dst_e), .dst_m (dst_m),
    .wr_e_en (wr_e_en), .wr_m_en (wr_m_en), .alu_a_sel (alu_a_sel), .alu_b_sel (alu_b_sel),
    .alu_fn (alu_fn), .cc_update (cc_update), .mem_rd (mem_rd), .mem_wr (mem_wr),
    .mem_addr_sel (mem_addr_sel), .mem_data_sel (mem_data_sel), .pc_sel (pc_sel),
    .branch_taken (branch_taken), .halt (halt), .illegal (illegal)
  );

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s op=%h fn=%h ra=%0d rb=%0d fl=%b actual=%0d expected=%0d",
               tag, op_code, op_fn, reg_a, reg_b, flags, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  // Expected-value model written from the requirements.
  task automatic check_all();
    int op, fn, ra, rb, zf, sf, ov;
    bit bad, alu, jmp, take, stk, lt;
    int e_sa, e_sb, e_de, e_dm, e_we, e_wm, e_asel, e_bsel, e_pc;
    op = op_code; fn = op_fn; ra = reg_a; rb = reg_b;
    zf = flags[0]; sf = flags[1]; ov = flags[2];
    alu = (op == 2) && (fn <= 3);
    jmp = (op == 7) && (fn <= 6);
    bad = (op >= 12) || (op == 2 && !alu) || (op == 7 && !jmp);
    stk = (op == 8) || (op == 9) || (op == 10) || (op == 11);
    lt  = (sf != ov);
    take = 1'b0;
    if (jmp) begin
      if (fn == 0) take = 1'b1;
      if (fn == 1) take = lt || zf == 1;
      if (fn == 2) take = lt;
      if (fn == 3) take = (zf == 1);
      if (fn == 4) take = (zf == 0);
      if (fn == 5) take = !lt;
      if (fn == 6) take = !lt && zf == 0;
    end
    e_sa = 8;
    if (alu || op == 3 || op == 5 || op == 10) e_sa = ra;
    if (op == 9 || op == 11) e_sa = 4;
    e_sb = stk ? 4 : ((alu || op == 5 || op == 6) ? rb : 8);
    e_de = stk ? 4 : ((alu || op == 3 || op == 4) ? rb : 8);
    e_dm = (op == 6 || op == 11) ? ra : 8;
    e_wm = (e_dm != 8);
    e_we = (e_de != 8) && !(e_de == e_dm && e_wm == 1);
    e_asel = 0;
    if (op == 4 || op == 5 || op == 6) e_asel = 1;
    if (op == 10 || op == 8) e_asel = 2;
    if (op == 11 || op == 9) e_asel = 3;
    e_bsel = (alu || op == 5 || op == 6 || stk);
    e_pc = (op == 9) ? 2 : ((op == 8 || take) ? 1 : 0);
    chk("R1 illegal", illegal, bad);
    chk("R1 halt", halt, op == 1);
    chk("R2 src_a", src_a, e_sa);
    chk("R3 src_b", src_b, e_sb);
    chk("R4 dst_e", dst_e, e_de);
    chk("R5 dst_m", dst_m, e_dm);
    chk("R6 wr_e_en", wr_e_en, e_we);
    chk("R6 wr_m_en", wr_m_en, e_wm);
    chk("R7 alu_a_sel", alu_a_sel, e_asel);
    chk("R7 alu_b_sel", alu_b_sel, e_bsel);
    chk("R8 cc_update", cc_update, alu);
    chk("R8 alu_fn", alu_fn, alu ? fn : 0);
    chk("R9 mem_wr", mem_wr, op == 5 || op == 10 || op == 8);
    chk("R9 mem_rd", mem_rd, op == 6 || op == 11 || op == 9);
    chk("R10 mem_addr_sel", mem_addr_sel, op == 11 || op == 9);
    chk("R10 mem_data_sel", mem_data_sel, op == 8);
    chk("R11 branch_taken", branch_taken, take);
    chk("R12 pc_sel", pc_sel, e_pc);
  endtask

  task automatic drive(input int op, input int fn, input int ra, input int rb, input int fl);
    @(negedge clk);
    op_code = 4'(op); op_fn = 4'(fn); reg_a = 4'(ra); reg_b = 4'(rb); flags = 3'(fl);
    #1;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    int regs [5];
    regs = '{0, 3, 4, 7, 8};
    op_code = '0; op_fn = '0; reg_a = '0; reg_b = '0; flags = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    // Idle state with all-zero inputs: nothing enabled.
    #1;
    chk("R1 idle wr_e_en", wr_e_en, 0);
    chk("R9 idle mem_wr", mem_wr, 0);
    chk("R12 idle pc_sel", pc_sel, 0);

    // Directed: pop of the stack pointer, M port wins (R6).
    drive(11, 0, 4, 8, 0);
    chk("R6 popsp dst_e", dst_e, 4);
    chk("R6 popsp dst_m", dst_m, 4);
    chk("R6 popsp wr_e_en", wr_e_en, 0);
    chk("R6 popsp wr_m_en", wr_m_en, 1);
    chk("R10 popsp addr old sp", mem_addr_sel, 1);
    // Directed: push of the stack pointer stores the old value (R13).
    drive(10, 0, 4, 8, 0);
    chk("R13 pushsp src_a", src_a, 4);
    chk("R13 pushsp data sel", mem_data_sel, 0);
    chk("R13 pushsp alu_a dec", alu_a_sel, 2);
    // Directed: jump greater not taken on zero (R11).
    drive(7, 6, 0, 0, 3'b001);
    chk("R11 jg on zero", branch_taken, 0);
    drive(7, 6, 0, 0, 3'b110);
    chk("R11 jg sign=ovf", branch_taken, 1);

    // Sweep: every opcode and function against chosen registers and all flags.
    for (int op = 0; op < 16; op++)
      for (int fn = 0; fn < 16; fn++)
        for (int ia = 0; ia < 5; ia++)
          for (int ib = 0; ib < 5; ib++)
            for (int fl = 0; fl < 8; fl++) begin
              if (fl != 0 && op != 7 && ia + ib != 0) continue;
              drive(op, fn, regs[ia], regs[ib], fl);
              check_all();
            end
    finish_run();
  end

endmodule